// File: doc/BRIEF.md
# Multi-Warp Fetch Scheduler

This block chooses, every cycle, which warp of a core sends its next instruction address toward instruction fetch. It holds an active mask, which warps are running, and a stalled mask, which warps already have an instruction in the front end. The lowest-numbered warp that is active and not stalled is offered to fetch with its warp index, program counter and thread mask. When fetch accepts the offer, that warp becomes stalled. It stays stalled until decode hands it back, so each warp has at most one instruction in flight ahead of decode.

Decode returns a warp with a release pulse. The pulse carries the warp's next program counter and a flag that keeps the warp stalled. A spawn command wakes extra warps at a common start address. A resume command un-stalls every warp at once. An exit event stops all warps and latches a sticky exit state. A 64-bit counter records every cycle in which no warp could be offered.

A two-state machine tracks the exit. In state SCH_RUN the block schedules normally. The transition SCH_RUN to SCH_EXITED is taken on the first exit event. SCH_EXITED is held until reset and drives the `exited` output.

Top module: `warp_fetch_sched`

## Requirements
- R1: `fetch_valid` is high exactly when some warp is active and not stalled. While it is high, `fetch_wid` is the lowest-numbered such warp, and `fetch_pc`/`fetch_tmask` are that warp's program counter and thread mask.
- R2: A warp is taken only in a cycle with `fetch_valid` and `fetch_ready` both high. Its bit in `stalled_mask` is 1 from the next cycle. Without `fetch_ready`, no stalled bit is set.
- R3: A release (`rel_valid`) for warp `rel_wid` loads that warp's program counter with `rel_pc` and clears its stalled bit in the next cycle. When `rel_fetch_stall` is 1, the stalled bit stays set.
- R4: `idle_count` (64 bits) rises by one after every cycle in which `fetch_valid` is low, and holds otherwise.
- R5: After reset, `active_mask` has only bit 0 set and `stalled_mask` is 0. Warp 0 has program counter `BOOT_PC` and thread mask 1 (thread 0 only). `idle_count` is 0 and `exited` is 0.
- R6: A spawn with count N activates warps 1 through min(N, NUM_WARPS)-1. Each of them gets `spawn_pc` and thread mask 1. Counts 0 and 1 activate nothing, and warp 0 is never changed by a spawn.
- R7: An exit event clears all of `active_mask` in the next cycle and sets `exited`. If a spawn arrives in the same cycle, the exit wins.
- R8: `resume` clears every stalled bit in the next cycle. A warp taken by fetch in that same cycle is still marked stalled.
- R9: `exited` stays 1 until reset, even if a later spawn makes warps active again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_ready | input | 1 | Fetch stage can take a warp this cycle |
| fetch_valid | output | 1 | A warp is offered to fetch |
| fetch_wid | output | WID_W | Index of the offered warp |
| fetch_pc | output | PC_W | Program counter of the offered warp |
| fetch_tmask | output | NUM_THREADS | Thread mask of the offered warp |
| rel_valid | input | 1 | Decode hands back a warp |
| rel_wid | input | WID_W | Warp being handed back |
| rel_pc | input | PC_W | Next program counter for that warp |
| rel_fetch_stall | input | 1 | Keep the warp stalled despite the release |
| spawn_valid | input | 1 | Spawn command |
| spawn_count | input | CNT_W | Requested number of warps, including warp 0 |
| spawn_pc | input | PC_W | Start address for spawned warps |
| resume | input | 1 | Clear all stalled bits |
| exit_evt | input | 1 | Exit event (ecall or ebreak) |
| active_mask | output | NUM_WARPS | Active warps |
| stalled_mask | output | NUM_WARPS | Stalled warps |
| exited | output | 1 | Sticky exit state |
| idle_count | output | 64 | Cycles with no eligible warp |

## Verification
The bench targets the cases where warps are taken back to back with `fetch_ready` high. A design that set stalled bits one cycle late would offer the same warp twice in a row.

It sends a release that carries the fetch-stall flag. A design that ignored the flag would put the warp back into the rotation too early.

It spawns with counts of 0, 1, a middle value and more than the warp count. An off-by-one limit would wake too many or too few warps, or would touch warp 0.

It fires a resume in the same cycle that fetch takes a warp, and an exit in the same cycle as a spawn. A design with the wrong priority would leave the taken warp free, or would keep warps alive after the exit.

// File: rtl/wfs_pkg.sv
package wfs_pkg;
    typedef enum logic [0:0] {
        SCH_RUN    = 1'b0,
        SCH_EXITED = 1'b1
    } sched_state_e;
endpackage

// File: rtl/wfs_pick.sv
module wfs_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  elig,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) idx = IW'(i);
        end
        any    = |elig;
        onehot = elig & ~(elig - N'(1));
    end
endmodule

// File: rtl/wfs_warp_ctx.sv
module wfs_warp_ctx #(
    parameter int                N       = 4,
    parameter int                PC_W    = 32,
    parameter int                THREADS = 4,
    parameter logic [PC_W-1:0]   BOOT_PC = '0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N-1:0]                  spawn_en,
    input  logic [PC_W-1:0]               spawn_pc,
    input  logic [N-1:0]                  rel_en,
    input  logic [PC_W-1:0]               rel_pc,
    output logic [N-1:0][PC_W-1:0]        pc_arr,
    output logic [N-1:0][THREADS-1:0]     tmask_arr
);
    localparam logic [THREADS-1:0] T0_ONLY = THREADS'(1);

    for (genvar g = 0; g < N; g++) begin : g_warp
        localparam logic [PC_W-1:0]    RST_PC = (g == 0) ? BOOT_PC : '0;
        localparam logic [THREADS-1:0] RST_TM = (g == 0) ? T0_ONLY : '0;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pc_arr[g]    <= RST_PC;
                tmask_arr[g] <= RST_TM;
            end else if (spawn_en[g]) begin
                pc_arr[g]    <= spawn_pc;
                tmask_arr[g] <= T0_ONLY;
            end else if (rel_en[g]) begin
                pc_arr[g]    <= rel_pc;
            end
        end
    end
endmodule

// File: rtl/wfs_idle_ctr.sv
module wfs_idle_ctr #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + W'(1);
    end
endmodule

// File: rtl/warp_fetch_sched.sv
module warp_fetch_sched
    import wfs_pkg::*;
#(
    parameter int              NUM_WARPS   = 4,
    parameter int              NUM_THREADS = 4,
    parameter int              PC_W        = 32,
    parameter int              CNT_W       = 8,
    parameter logic [PC_W-1:0] BOOT_PC     = 32'h0000_0080,
    localparam int             WID_W       = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fetch_ready,
    output logic                   fetch_valid,
    output logic [WID_W-1:0]       fetch_wid,
    output logic [PC_W-1:0]        fetch_pc,
    output logic [NUM_THREADS-1:0] fetch_tmask,
    input  logic                   rel_valid,
    input  logic [WID_W-1:0]       rel_wid,
    input  logic [PC_W-1:0]        rel_pc,
    input  logic                   rel_fetch_stall,
    input  logic                   spawn_valid,
    input  logic [CNT_W-1:0]       spawn_count,
    input  logic [PC_W-1:0]        spawn_pc,
    input  logic                   resume,
    input  logic                   exit_evt,
    output logic [NUM_WARPS-1:0]   active_mask,
    output logic [NUM_WARPS-1:0]   stalled_mask,
    output logic                   exited,
    output logic [63:0]            idle_count
);
    localparam int N = NUM_WARPS;

    sched_state_e state_q, state_d;

    logic [N-1:0] active_q, active_d;
    logic [N-1:0] stalled_q, stalled_d;
    logic [N-1:0] elig, pick_oh, spawn_en, rel_en, rel_clr;
    logic [WID_W-1:0] pick_idx;
    logic             pick_any, take;
    logic [N-1:0][PC_W-1:0]        pc_arr;
    logic [N-1:0][NUM_THREADS-1:0] tmask_arr;

    assign elig = active_q & ~stalled_q;

    wfs_pick #(.N(N), .IW(WID_W)) u_pick (
        .elig   (elig),
        .any    (pick_any),
        .idx    (pick_idx),
        .onehot (pick_oh)
    );

    assign take = pick_any & fetch_ready;

    // warps that a spawn command wakes: 1 .. min(count, N)-1
    for (genvar g = 0; g < N; g++) begin : g_spawn
        if (g == 0) begin : g_w0
            assign spawn_en[g] = 1'b0;
        end else begin : g_wn
            assign spawn_en[g] = spawn_valid && (spawn_count > CNT_W'(g));
        end
        assign rel_en[g] = rel_valid && (rel_wid == WID_W'(g));
    end

    assign rel_clr = rel_en & {N{~rel_fetch_stall}};

    wfs_warp_ctx #(
        .N(N), .PC_W(PC_W), .THREADS(NUM_THREADS), .BOOT_PC(BOOT_PC)
    ) u_ctx (
        .clk       (clk),
        .rst_n     (rst_n),
        .spawn_en  (spawn_en),
        .spawn_pc  (spawn_pc),
        .rel_en    (rel_en),
        .rel_pc    (rel_pc),
        .pc_arr    (pc_arr),
        .tmask_arr (tmask_arr)
    );

    wfs_idle_ctr #(.W(64)) u_idle (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (~pick_any),
        .count (idle_count)
    );

    always_comb begin
        stalled_d = stalled_q & ~rel_clr;
        if (resume) stalled_d = '0;
        if (take)   stalled_d = stalled_d | pick_oh;

        active_d = active_q | spawn_en;
        if (exit_evt) active_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q  <= N'(1);
            stalled_q <= '0;
        end else begin
            active_q  <= active_d;
            stalled_q <= stalled_d;
        end
    end

    // exit state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SCH_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCH_RUN:    if (exit_evt) state_d = SCH_EXITED;
            SCH_EXITED: state_d = SCH_EXITED;
            default:    state_d = SCH_RUN;
        endcase
    end

    // outputs
    always_comb begin
        exited       = (state_q == SCH_EXITED);
        fetch_valid  = pick_any;
        fetch_wid    = pick_idx;
        fetch_pc     = pc_arr[pick_idx];
        fetch_tmask  = tmask_arr[pick_idx];
        active_mask  = active_q;
        stalled_mask = stalled_q;
    end
endmodule

// File: rtl/warp_fetch_sched_chk.sv
module warp_fetch_sched_chk #(
    parameter int NUM_WARPS = 4,
    parameter int WID_W     = 2,
    parameter int PC_W      = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fetch_ready,
    input logic                 fetch_valid,
    input logic [WID_W-1:0]     fetch_wid,
    input logic                 rel_valid,
    input logic [WID_W-1:0]     rel_wid,
    input logic                 rel_fetch_stall,
    input logic                 resume,
    input logic                 exit_evt,
    input logic [NUM_WARPS-1:0] active_mask,
    input logic [NUM_WARPS-1:0] stalled_mask,
    input logic                 exited,
    input logic [63:0]          idle_count
);
    logic [NUM_WARPS-1:0] free_w, below_w;
    assign free_w  = active_mask & ~stalled_mask;
    assign below_w = (NUM_WARPS'(1) << fetch_wid) - NUM_WARPS'(1);

    // R1
    lowest_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> (free_w[fetch_wid] && ((free_w & below_w) == '0)));

    // R2
    stall_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_ready) |=> stalled_mask[$past(fetch_wid)]);

    // R3
    release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && !rel_fetch_stall &&
         !(fetch_valid && fetch_ready && fetch_wid == rel_wid))
        |=> !stalled_mask[$past(rel_wid)]);

    // R4
    idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> idle_count == $past(idle_count) + 64'd1);

    // R7
    exit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exit_evt |=> (active_mask == '0) && exited);

    // R8
    resume_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resume && !(fetch_valid && fetch_ready)) |=> stalled_mask == '0);

    // R9
    exit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exited |=> exited);
endmodule

bind warp_fetch_sched warp_fetch_sched_chk #(
    .NUM_WARPS(NUM_WARPS), .WID_W(WID_W), .PC_W(PC_W)
) u_chk (.*);

// File: tb/warp_fetch_sched_test.sv
`timescale 1ns/1ps
module warp_fetch_sched_test;
    localparam int          NW    = 4;
    localparam int          WW    = 2;
    localparam logic [31:0] BOOT  = 32'h0000_0080;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fetch_ready = 1'b0, fetch_valid;
    logic [WW-1:0] fetch_wid;
    logic [31:0] fetch_pc;
    logic [3:0] fetch_tmask;
    logic rel_valid = 1'b0, rel_fetch_stall = 1'b0;
    logic [WW-1:0] rel_wid = '0;
    logic [31:0] rel_pc = '0;
    logic spawn_valid = 1'b0;
    logic [7:0] spawn_count = '0;
    logic [31:0] spawn_pc = '0;
    logic resume = 1'b0, exit_evt = 1'b0;
    logic [NW-1:0] active_mask, stalled_mask;
    logic exited;
    logic [63:0] idle_count;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    warp_fetch_sched uut (.*);

    // spawn table: {count[7:0], 4'b0, expected active mask[3:0]}
    localparam logic [15:0] SPAWN_TBL [6] = '{
        16'h00_01, 16'h01_01, 16'h02_03, 16'h03_07, 16'h04_0F, 16'h09_0F
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        fetch_ready = 0; rel_valid = 0; spawn_valid = 0; resume = 0; exit_evt = 0;
        cycle(); cycle();
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [63:0] idle0;

        // R6 table walk: spawn limits
        for (int i = 0; i < 6; i++) begin
            do_reset();
            spawn_valid = 1; spawn_count = SPAWN_TBL[i][15:8]; spawn_pc = 32'h1000;
            cycle();
            spawn_valid = 0;
            check($sformatf("R6 spawn count %0d", SPAWN_TBL[i][15:8]),
                  64'(active_mask), 64'(SPAWN_TBL[i][3:0]));
        end

        // R5 reset state
        do_reset();
        check("R5 active", 64'(active_mask), 64'h1);
        check("R5 stalled", 64'(stalled_mask), 64'h0);
        check("R5 pc", 64'(fetch_pc), 64'(BOOT));
        check("R5 tmask", 64'(fetch_tmask), 64'h1);
        check("R5 idle", idle_count, 64'h0);
        check("R5 exited", 64'(exited), 64'h0);

        // R2 no take without ready
        cycle();
        check("R2 no ready keeps stalled", 64'(stalled_mask), 64'h0);
        check("R1 valid warp0", 64'({fetch_valid, fetch_wid}), 64'({1'b1, 2'd0}));

        spawn_valid = 1; spawn_count = 8'd4; spawn_pc = 32'h1000;
        cycle();
        spawn_valid = 0;
        check("R6 all active", 64'(active_mask), 64'hF);

        // R1/R2 back-to-back takes
        fetch_ready = 1;
        cycle();
        check("R2 warp0 stalled", 64'(stalled_mask), 64'h1);
        check("R1 next warp1", 64'(fetch_wid), 64'd1);
        check("R6 spawned pc", 64'(fetch_pc), 64'h1000);
        check("R6 spawned tmask", 64'(fetch_tmask), 64'h1);
        cycle();
        check("R1 next warp2", 64'(fetch_wid), 64'd2);
        cycle();
        check("R1 next warp3", 64'(fetch_wid), 64'd3);
        cycle();
        check("R2 all stalled", 64'(stalled_mask), 64'hF);
        check("R1 no valid", 64'(fetch_valid), 64'h0);
        fetch_ready = 0;

        // R4 idle counting
        idle0 = idle_count;
        cycle(); cycle(); cycle();
        check("R4 idle +3", idle_count, idle0 + 64'd3);

        // R3 release with fetch-stall flag keeps warp stalled
        rel_valid = 1; rel_wid = 2'd2; rel_fetch_stall = 1; rel_pc = 32'h2000;
        cycle();
        rel_valid = 0; rel_fetch_stall = 0;
        check("R3 stall flag keeps stall", 64'(stalled_mask), 64'hF);
        rel_valid = 1; rel_wid = 2'd2; rel_pc = 32'h2200;
        cycle();
        rel_valid = 0;
        check("R3 release clears", 64'(stalled_mask), 64'hB);
        check("R3 released warp offered", 64'(fetch_wid), 64'd2);
        check("R3 released pc", 64'(fetch_pc), 64'h2200);

        // R8 resume
        resume = 1;
        cycle();
        resume = 0;
        check("R8 resume clears all", 64'(stalled_mask), 64'h0);
        fetch_ready = 1;
        cycle();
        check("R2 take warp0", 64'(stalled_mask), 64'h1);
        resume = 1;
        cycle();
        resume = 0; fetch_ready = 0;
        check("R8 take wins over resume", 64'(stalled_mask), 64'h2);

        // R7 exit beats spawn
        spawn_valid = 1; spawn_count = 8'd4; exit_evt = 1;
        cycle();
        spawn_valid = 0; exit_evt = 0;
        check("R7 active cleared", 64'(active_mask), 64'h0);
        check("R7 exited set", 64'(exited), 64'h1);
        check("R7 no valid", 64'(fetch_valid), 64'h0);

        // R9 sticky exit across a later spawn
        spawn_valid = 1; spawn_count = 8'd3; spawn_pc = 32'h3000;
        cycle();
        spawn_valid = 0;
        check("R9 spawn after exit", 64'(active_mask), 64'h6);
        check("R9 exited sticky", 64'(exited), 64'h1);
        check("R1 skips stalled warp1", 64'(fetch_wid), 64'd2);
        check("R6 pc after exit", 64'(fetch_pc), 64'h3000);
        do_reset();
        check("R9 reset clears exited", 64'(exited), 64'h0);
        check("R5 active after reset", 64'(active_mask), 64'h1);

        done = 1'b1;
        finish_run();
    end
endmodule